// File: doc/BRIEF.md
# Timer Compare Channel with Fast Trigger Path

This block is one compare channel of a general-purpose timer. It compares a counter value supplied from outside with a compare value and forms a reference waveform. From that reference it drives a main output and a complementary output, each with its own enable and polarity. A register port holds the channel configuration. That configuration includes the channel direction, the compare mode, the output enables and polarities, and a fast-trigger option.

An external trigger is synchronised and edge-detected. The block emits a one-cycle trigger event so that the surrounding timer can restart its counter. With the fast option set, the trigger edge itself counts as a compare match, so a one-pulse output starts two cycles earlier than it would through the counter. Field writes are guarded. The direction field cannot change while the channel is enabled. The complementary polarity is frozen by a lock level. That polarity can also be held in a shadow register until a commutation event arrives.

Top module: `tcc_chan`

## Requirements
- R1: After reset, both registers read zero and both outputs are low.
- R2: The direction field (register 1, bits 1:0) accepts 00 (output) and 01 (input from input 1). A write of 10 or 11 leaves the field unchanged. When the direction is not 00, both outputs are low.
- R3: A write to the direction field takes effect only while the channel enable (register 0, bit 0) is 0. Otherwise it is ignored.
- R4: The mode field (register 1, bits 5:4) selects the reference: 00 holds its last value, 01 is high while cnt < cmp, 10 is high while cnt >= cmp, and 11 is constant high. The reference is registered one clock after its inputs. Register 0 holds the output controls: bit 0 main enable, bit 1 complementary enable, bit 2 main polarity, bit 3 complementary polarity. In output direction, oc = main enable AND (reference XOR main polarity). Under the same condition, ocn = complementary enable AND (NOT reference XOR active complementary polarity).
- R5: When fast enable (register 1, bit 3) is set in mode 01 or 10, a trigger rising edge forces the reference high. The reference stays forced until the trigger event has passed. The output goes active at the third rising clock edge after trig_in rises.
- R6: trig_event is a single-cycle pulse, high after the third clock edge following a trig_in rise. With fast enable clear and a counter that restarts on that pulse, the output goes active at the fifth edge.
- R7: Fast enable has no effect in modes 00 and 11.
- R8: A write to the complementary polarity bit is ignored while lock_level is 2 or 3 and the direction is 00. It is accepted in the input direction or at a lower lock level.
- R9: With com_preload high, the active complementary polarity takes the written (preloaded) value only on a com_event clock. Register 0 bit 3 reads back the preloaded value.
- R10: With com_preload low, a written complementary polarity drives ocn from the clock edge of the write.
- R11: Register bits 15:4 of register 0, and bits 15:6 and bit 2 of register 1, read as zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | Register select for read and write (0 output control, 1 channel mode) |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| lock_level | input | 2 | Write-protection level, 0 unlocked |
| com_preload | input | 1 | Hold complementary polarity until a commutation event |
| com_event | input | 1 | Commutation event strobe |
| cnt | input | 16 | Timer counter value |
| cmp | input | 16 | Compare value |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_event | output | 1 | One-cycle pulse on a trigger rising edge |
| oc | output | 1 | Main compare output |
| ocn | output | 1 | Complementary compare output |

## Verification
Some properties are checked on every cycle. The direction field never holds a reserved code and never moves while the channel is enabled. The complementary polarity stays put under lock and stays put between commutation events when preload is on. The fast path forces the reference one edge after a trigger edge, and the trigger event lasts a single cycle. Other behaviour only the bench's scenarios can show: the exact three-versus-five edge latency against a restarting counter, the compare arithmetic and polarity combinations, fast enable being ignored in non-PWM modes, and the readback of reserved bits.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  localparam int unsigned REG_W = 16;

  typedef enum logic [1:0] {
    OM_HOLD   = 2'b00,
    OM_PWM_LO = 2'b01,
    OM_PWM_HI = 2'b10,
    OM_ACTIVE = 2'b11
  } oc_mode_e;

  localparam logic [1:0] DIR_OUT = 2'b00;
  localparam logic [1:0] DIR_IN1 = 2'b01;

  typedef struct packed {
    logic     en;
    logic     nen;
    logic     pol;
    logic     npol_pre;
    logic     npol_act;
    logic [1:0] dir;
    logic     fast;
    oc_mode_e mode;
  } chan_cfg_t;

endpackage

// File: rtl/tcc_regs.sv
module tcc_regs
  import tcc_pkg::*;
#(
  parameter int unsigned DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    lock_level,
  input  logic          com_preload,
  input  logic          com_event,
  output logic [DW-1:0] rd_data,
  output chan_cfg_t     cfg
);

  localparam int unsigned LOCK_NPOL = 2;

  chan_cfg_t cfg_q, cfg_n;
  logic      ctl_wr, mode_wr, npol_locked, dir_legal;

  always_comb begin
    ctl_wr      = wr_en && (addr == 1'b0);
    mode_wr     = wr_en && (addr == 1'b1);
    npol_locked = (lock_level >= 2'(LOCK_NPOL)) && (cfg_q.dir == DIR_OUT);
    dir_legal   = (wr_data[1:0] == DIR_OUT) || (wr_data[1:0] == DIR_IN1);
    cfg_n       = cfg_q;
    if (ctl_wr) begin
      cfg_n.en  = wr_data[0];
      cfg_n.nen = wr_data[1];
      cfg_n.pol = wr_data[2];
      if (!npol_locked) begin
        cfg_n.npol_pre = wr_data[3];
      end
    end
    if (mode_wr) begin
      if (!cfg_q.en && dir_legal) begin
        cfg_n.dir = wr_data[1:0];
      end
      cfg_n.fast = wr_data[3];
      cfg_n.mode = oc_mode_e'(wr_data[5:4]);
    end
    if (com_preload) begin
      if (com_event) begin
        cfg_n.npol_act = cfg_q.npol_pre;
      end
    end else begin
      cfg_n.npol_act = cfg_n.npol_pre;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else begin
      cfg_q <= cfg_n;
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == 1'b0) begin
      rd_data[3:0] = {cfg_q.npol_pre, cfg_q.pol, cfg_q.nen, cfg_q.en};
    end else begin
      rd_data[5:0] = {cfg_q.mode, cfg_q.fast, 1'b0, cfg_q.dir};
    end
  end

  assign cfg = cfg_q;

endmodule

// File: rtl/tcc_trig_sync.sv
module tcc_trig_sync #(
  parameter int unsigned SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic rise,
  output logic event_q
);

  localparam int unsigned CHAIN_W = SYNC_N + 1;

  logic [CHAIN_W-1:0] chain_q, chain_n;
  logic               event_n;

  always_comb begin
    chain_n = {chain_q[CHAIN_W-2:0], trig_in};
    rise    = chain_q[SYNC_N-1] & ~chain_q[SYNC_N];
    event_n = rise;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      event_q <= 1'b0;
    end else begin
      chain_q <= chain_n;
      event_q <= event_n;
    end
  end

endmodule

// File: rtl/tcc_out_gen.sv
module tcc_out_gen
  import tcc_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  chan_cfg_t     cfg,
  input  logic          rise,
  input  logic          trig_evt,
  output logic          ref_q,
  output logic          oc,
  output logic          ocn
);

  logic ref_n, below, pwm, force_hi, drive;

  always_comb begin
    below    = cnt < cmp;
    pwm      = (cfg.mode == OM_PWM_LO) || (cfg.mode == OM_PWM_HI);
    force_hi = cfg.fast && pwm && (rise || trig_evt);
    unique case (cfg.mode)
      OM_HOLD:   ref_n = ref_q;
      OM_PWM_LO: ref_n = below;
      OM_PWM_HI: ref_n = !below;
      default:   ref_n = 1'b1;
    endcase
    if (force_hi) begin
      ref_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= 1'b0;
    end else begin
      ref_q <= ref_n;
    end
  end

  always_comb begin
    drive = (cfg.dir == DIR_OUT);
    oc    = drive && cfg.en  && (ref_q ^ cfg.pol);
    ocn   = drive && cfg.nen && (!ref_q ^ cfg.npol_act);
  end

endmodule

// File: rtl/tcc_chan.sv
module tcc_chan
  import tcc_pkg::*;
#(
  parameter int unsigned CW     = 16,
  parameter int unsigned DW     = REG_W,
  parameter int unsigned SYNC_N = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic [1:0]    lock_level,
  input  logic          com_preload,
  input  logic          com_event,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cmp,
  input  logic          trig_in,
  output logic          trig_event,
  output logic          oc,
  output logic          ocn
);

  chan_cfg_t  cfg;
  logic       rise, ref_q;
  logic       en, fast, npol_pre, npol_act;
  logic [1:0] dir, mode;

  tcc_regs #(.DW(DW)) regs_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .lock_level(lock_level), .com_preload(com_preload), .com_event(com_event),
    .rd_data(rd_data), .cfg(cfg)
  );

  tcc_trig_sync #(.SYNC_N(SYNC_N)) sync_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise), .event_q(trig_event)
  );

  tcc_out_gen #(.CW(CW)) out_i (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cmp(cmp), .cfg(cfg), .rise(rise),
    .trig_evt(trig_event), .ref_q(ref_q), .oc(oc), .ocn(ocn)
  );

  assign en       = cfg.en;
  assign fast     = cfg.fast;
  assign npol_pre = cfg.npol_pre;
  assign npol_act = cfg.npol_act;
  assign dir      = cfg.dir;
  assign mode     = cfg.mode;

endmodule

// File: rtl/tcc_chan_chk.sv
module tcc_chan_chk #(
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          addr,
  input logic [DW-1:0] rd_data,
  input logic [1:0]    lock_level,
  input logic          com_preload,
  input logic          com_event,
  input logic          en,
  input logic          fast,
  input logic          npol_pre,
  input logic          npol_act,
  input logic [1:0]    dir,
  input logic [1:0]    mode,
  input logic          rise,
  input logic          ref_q,
  input logic          trig_event
);

  p_dir_legal_r2: assert property (@(posedge clk) disable iff (!rst_n) !dir[1]);

  p_dir_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(dir));

  p_fast_force_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && (mode == 2'b01 || mode == 2'b10) && rise) |=> ref_q);

  p_evt_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig_event |=> !trig_event);

  p_npol_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_level >= 2'd2 && dir == 2'b00) |=> $stable(npol_pre));

  p_npol_shadow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (com_preload && !com_event) |=> $stable(npol_act));

  p_rsv_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == 1'b0) |-> (rd_data[DW-1:4] == '0));

endmodule

bind tcc_chan tcc_chan_chk #(.DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .rd_data(rd_data),
  .lock_level(lock_level), .com_preload(com_preload), .com_event(com_event),
  .en(en), .fast(fast), .npol_pre(npol_pre), .npol_act(npol_act), .dir(dir),
  .mode(mode), .rise(rise), .ref_q(ref_q), .trig_event(trig_event)
);

// File: tb/tcc_chan_tb.sv
module tcc_chan_tb_top;

  localparam int unsigned CW = 16;
  localparam int unsigned DW = 16;
  localparam time         HALF = 10ns;

  // vector: {mode[2], pol, npol, cnt[8], cmp[8], exp_oc, exp_ocn}
  localparam int unsigned NV = 8;
  localparam logic [21:0] VEC [NV] = '{
    {2'b01, 1'b0, 1'b0, 8'd3, 8'd5, 1'b1, 1'b0},
    {2'b01, 1'b0, 1'b0, 8'd5, 8'd5, 1'b0, 1'b1},
    {2'b10, 1'b0, 1'b0, 8'd5, 8'd5, 1'b1, 1'b0},
    {2'b10, 1'b0, 1'b0, 8'd2, 8'd5, 1'b0, 1'b1},
    {2'b01, 1'b1, 1'b0, 8'd3, 8'd5, 1'b0, 1'b0},
    {2'b01, 1'b0, 1'b1, 8'd9, 8'd5, 1'b0, 1'b0},
    {2'b11, 1'b0, 1'b0, 8'd7, 8'd2, 1'b1, 1'b0},
    {2'b10, 1'b1, 1'b1, 8'd0, 8'd0, 1'b0, 1'b1}
  };

  logic          clk, rst_n, wr_en, addr, com_preload, com_event, trig_in;
  logic [DW-1:0] wr_data, rd_data;
  logic [1:0]    lock_level;
  logic [CW-1:0] cnt, cmp;
  logic          trig_event, oc, ocn;
  int            n_chk, n_err;
  bit            done;

  tcc_chan #(.CW(CW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .lock_level(lock_level), .com_preload(com_preload),
    .com_event(com_event), .cnt(cnt), .cmp(cmp), .trig_in(trig_in),
    .trig_event(trig_event), .oc(oc), .ocn(ocn)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [DW-1:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic a, input logic [DW-1:0] exp, input string req);
    addr = a;
    #1;
    check(req, 32'(rd_data), 32'(exp));
  endtask

  task automatic latency(input logic fst, input string req);
    wr(1'b0, 16'h0001);
    wr(1'b1, {10'b0, 2'b01, fst, 3'b000});
    cnt = 16'd10; cmp = 16'd10; trig_in = 1'b0;
    repeat (5) @(negedge clk);
    check(req, 32'(oc), 32'd0);
    trig_in = 1'b1;
    begin
      bit seen = 1'b0;
      for (int i = 1; i <= 6; i++) begin
        @(negedge clk);
        check(req, 32'(oc), 32'((fst ? (i >= 3) : (i >= 5))));
        if (i == 3) check("R6", 32'(trig_event), 32'd1);
        if (i == 4) check("R6", 32'(trig_event), 32'd0);
        if (seen) cnt = 16'd0;
        if (trig_event) seen = 1'b1;
      end
    end
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    #(2 * HALF * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    n_chk = 0; n_err = 0; done = 1'b0;
    rst_n = 1'b0; wr_en = 1'b0; addr = 1'b0; wr_data = '0;
    lock_level = 2'd0; com_preload = 1'b0; com_event = 1'b0;
    cnt = '0; cmp = '0; trig_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd_chk(1'b0, 16'h0000, "R1");
    rd_chk(1'b1, 16'h0000, "R1");
    check("R1", 32'({oc, ocn}), 32'd0);

    // R4 vector table with both enables on and direction output
    wr(1'b0, 16'h0003);
    for (int v = 0; v < NV; v++) begin
      cnt = CW'(VEC[v][17:10]);
      cmp = CW'(VEC[v][9:2]);
      wr(1'b0, {12'b0, VEC[v][18], VEC[v][19], 2'b11});
      wr(1'b1, {10'b0, VEC[v][21:20], 4'b0000});
      @(negedge clk);
      check("R4 oc", 32'(oc), 32'(VEC[v][1]));
      check("R4 ocn", 32'(ocn), 32'(VEC[v][0]));
    end

    // R2 / R3 direction rules
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0031);
    rd_chk(1'b1, 16'h0031, "R2");
    wr(1'b0, 16'h0003);
    @(negedge clk);
    check("R2 input dir outputs low", 32'({oc, ocn}), 32'd0);
    wr(1'b1, 16'h0030);
    rd_chk(1'b1, 16'h0031, "R3");
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0032);
    rd_chk(1'b1, 16'h0031, "R2 reserved code");
    wr(1'b1, 16'h0030);
    rd_chk(1'b1, 16'h0030, "R3");

    // R11 reserved bits
    wr(1'b0, 16'hFFFF);
    rd_chk(1'b0, 16'h000F, "R11");
    wr(1'b1, 16'hFFFF);
    rd_chk(1'b1, 16'h0038, "R11");
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0000);

    // R5 fast path, R6 normal path
    latency(1'b1, "R5");
    latency(1'b0, "R6");

    // R7 fast ignored in hold mode
    wr(1'b0, 16'h0001);
    wr(1'b1, 16'h0010);
    cnt = 16'd10; cmp = 16'd10;
    @(negedge clk);
    wr(1'b1, 16'h0008);
    trig_in = 1'b1;
    repeat (6) @(negedge clk);
    check("R7", 32'(oc), 32'd0);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);

    // R8 lock on complementary polarity
    wr(1'b0, 16'h0000);
    lock_level = 2'd2;
    wr(1'b0, 16'h0008);
    rd_chk(1'b0, 16'h0000, "R8 locked");
    wr(1'b1, 16'h0001);
    wr(1'b0, 16'h0008);
    rd_chk(1'b0, 16'h0008, "R8 input dir");
    wr(1'b0, 16'h0000);
    wr(1'b1, 16'h0000);
    lock_level = 2'd1;
    wr(1'b0, 16'h0008);
    rd_chk(1'b0, 16'h0008, "R8 low lock");
    lock_level = 2'd0;
    wr(1'b0, 16'h0000);

    // R9 preload with commutation
    wr(1'b1, 16'h0030);
    wr(1'b0, 16'h0002);
    @(negedge clk);
    check("R9 before", 32'(ocn), 32'd0);
    com_preload = 1'b1;
    wr(1'b0, 16'h000A);
    repeat (2) @(negedge clk);
    check("R9 held", 32'(ocn), 32'd0);
    rd_chk(1'b0, 16'h000A, "R9 readback");
    com_event = 1'b1;
    @(negedge clk);
    com_event = 1'b0;
    check("R9 commuted", 32'(ocn), 32'd1);

    // R10 immediate update
    com_preload = 1'b0;
    wr(1'b0, 16'h0002);
    check("R10", 32'(ocn), 32'd0);

    finish_run();
  end

endmodule